// File: doc/BRIEF.md
# Multi-type interrupt request generator

This block receives a raise request from a requester. The request carries a two-bit kind code and a vector number, and the block raises exactly one kind of interrupt. The three kinds are a level-sensitive legacy line, a message-signalled vector request, and an extended message-signalled vector request. Before the block drives any output, it checks the number against the legal range for the requested kind. A request that fails the check gets a one-cycle error pulse and leaves every output untouched.

Each message output is a valid/acknowledge handshake toward a separate message sender, which builds the actual memory write. The block passes the vector on that handshake as a zero-based index. Only one raise can be outstanding at a time. The legacy line counts as outstanding until the requester clears it, and a message request counts as outstanding until its sender acknowledges it. Any request that arrives in that window is refused with a busy pulse.

Top module: `intr_dispatch`

## Requirements
- R1: Kind code 0 selects legacy and accepts only number 0. One cycle after such a request is sampled while idle, `legacyIrq` is 1 and `reqDone` pulses for that one cycle.
- R2: `legacyIrq` stays 1 until `clrLegacy` is sampled high. It is 0 in the cycle after that edge.
- R3: Kind code 1 selects MSI and accepts numbers 1 to 32. One cycle after acceptance, `msiValid` is 1 and `msiVector` equals number minus 1. Both hold steady until `msiAck` is sampled.
- R4: Kind code 2 selects MSI-X and accepts numbers 1 to 2048. One cycle after acceptance, `msixValid` is 1 and `msixVector` equals number minus 1. Both hold steady until `msixAck` is sampled.
- R5: When an acknowledge is sampled while its valid is high, that valid is 0 one cycle later, and `reqDone` pulses in the same cycle.
- R6: Kind code 3, a nonzero legacy number, MSI number 0 or above 32, or MSI-X number 0 or above 2048 makes `reqErr` pulse one cycle after the request. No interrupt output changes.
- R7: A request sampled while a raise is outstanding makes `reqBusy` pulse one cycle later. The outstanding output and its vector stay as they were.
- R8: After reset all outputs are 0, and at no time is more than one of `legacyIrq`, `msiValid` and `msixValid` high.
- R9: Two kinds of input are ignored. One is `clrLegacy` while the legacy line is low. The other is `msiAck` or `msixAck` while the matching valid is low. Neither changes any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Raise request strobe, one cycle |
| reqKind | input | 2 | Interrupt kind: 0 legacy, 1 MSI, 2 MSI-X, 3 reserved |
| reqNum | input | NUM_W (12) | Requested vector number, one-based for message kinds |
| reqDone | output | 1 | One-cycle pulse: raise completed |
| reqErr | output | 1 | One-cycle pulse: request rejected as illegal |
| reqBusy | output | 1 | One-cycle pulse: request refused, raise outstanding |
| clrLegacy | input | 1 | Requester clears the legacy line |
| legacyIrq | output | 1 | Level legacy interrupt line |
| msiValid | output | 1 | MSI vector request valid |
| msiVector | output | 5 | Zero-based MSI vector |
| msiAck | input | 1 | MSI sender acknowledge |
| msixValid | output | 1 | MSI-X vector request valid |
| msixVector | output | 11 | Zero-based MSI-X vector |
| msixAck | input | 1 | MSI-X sender acknowledge |

## Verification
Every result is registered once. It appears in the cycle after the edge that samples the request, clear or acknowledge. So `reqDone`, `reqErr` and `reqBusy`, a rising valid, and a dropping line are each due exactly one cycle after the stimulus. The bench drives inputs just after a rising edge. When it drives a stimulus, it queues the expected result. A monitor samples on falling edges, and on each pulse or rising valid it takes the oldest queued result and compares it. The bench makes level checks for holding, stability and ignored inputs on the falling edge after the relevant cycle. Any result left in the queue at the end counts as a failure.

// File: rtl/intr_pkg.sv
package intr_pkg;

  typedef enum logic [1:0] {
    KIND_LEGACY = 2'd0,
    KIND_MSI    = 2'd1,
    KIND_MSIX   = 2'd2,
    KIND_RSVD   = 2'd3
  } irqKind_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LEG,
    ST_MSI,
    ST_MSIX
  } ctrlState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic setLeg;
    logic clrLeg;
    logic setMsi;
    logic clrMsi;
    logic setMsix;
    logic clrMsix;
    logic pulseDone;
    logic pulseErr;
    logic pulseBusy;
  } ctrlStrobe_t;

endpackage

// File: rtl/intr_vec_chan.sv
module intr_vec_chan #(
  parameter int NUM_W = 12,
  parameter int VW    = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             setReq,
  input  logic             clrReq,
  input  logic [NUM_W-1:0] num,
  output logic             valid,
  output logic [VW-1:0]    vector
);

  logic [NUM_W-1:0] zeroBased;
  assign zeroBased = num - NUM_W'(1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      valid  <= 1'b0;
      vector <= '0;
    end else if (setReq) begin
      valid  <= 1'b1;
      vector <= zeroBased[VW-1:0];
    end else if (clrReq) begin
      valid  <= 1'b0;
    end
  end

endmodule

// File: rtl/intr_datapath.sv
module intr_datapath
  import intr_pkg::*;
#(
  parameter int NUM_W    = 12,
  parameter int MSI_MAX  = 32,
  parameter int MSIX_MAX = 2048,
  localparam int MSI_VW  = $clog2(MSI_MAX),
  localparam int MSIX_VW = $clog2(MSIX_MAX)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [1:0]         reqKind,
  input  logic [NUM_W-1:0]   reqNum,
  input  ctrlStrobe_t        strobe,
  output logic               numLegal,
  output logic               reqDone,
  output logic               reqErr,
  output logic               reqBusy,
  output logic               legacyIrq,
  output logic               msiValid,
  output logic [MSI_VW-1:0]  msiVector,
  output logic               msixValid,
  output logic [MSIX_VW-1:0] msixVector
);

  localparam int NUM_CH = 2;

  logic               chSet [NUM_CH];
  logic               chClr [NUM_CH];
  logic               chValid [NUM_CH];
  logic [MSIX_VW-1:0] chVec [NUM_CH];

  // range check for the requested kind
  always_comb begin
    case (irqKind_e'(reqKind))
      KIND_LEGACY: numLegal = (reqNum == '0);
      KIND_MSI:    numLegal = (reqNum != '0) && (reqNum <= NUM_W'(MSI_MAX));
      KIND_MSIX:   numLegal = (reqNum != '0) && (reqNum <= NUM_W'(MSIX_MAX));
      default:     numLegal = 1'b0;
    endcase
  end

  assign chSet[0] = strobe.setMsi;
  assign chClr[0] = strobe.clrMsi;
  assign chSet[1] = strobe.setMsix;
  assign chClr[1] = strobe.clrMsix;

  for (genvar g = 0; g < NUM_CH; g++) begin : gChan
    localparam int CW = (g == 0) ? MSI_VW : MSIX_VW;
    logic [CW-1:0] vecOut;
    intr_vec_chan #(.NUM_W(NUM_W), .VW(CW)) uChan (
      .clk    (clk),
      .rstN   (rstN),
      .setReq (chSet[g]),
      .clrReq (chClr[g]),
      .num    (reqNum),
      .valid  (chValid[g]),
      .vector (vecOut)
    );
    assign chVec[g] = MSIX_VW'(vecOut);
  end

  assign msiValid   = chValid[0];
  assign msiVector  = chVec[0][MSI_VW-1:0];
  assign msixValid  = chValid[1];
  assign msixVector = chVec[1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      legacyIrq <= 1'b0;
      reqDone   <= 1'b0;
      reqErr    <= 1'b0;
      reqBusy   <= 1'b0;
    end else begin
      if (strobe.setLeg)      legacyIrq <= 1'b1;
      else if (strobe.clrLeg) legacyIrq <= 1'b0;
      reqDone <= strobe.pulseDone;
      reqErr  <= strobe.pulseErr;
      reqBusy <= strobe.pulseBusy;
    end
  end

endmodule

// File: rtl/intr_ctrl.sv
module intr_ctrl
  import intr_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic [1:0]  reqKind,
  input  logic        numLegal,
  input  logic        clrLegacy,
  input  logic        msiAck,
  input  logic        msixAck,
  output ctrlStrobe_t strobe
);

  ctrlState_e stateQ, stateNext;

  always_comb begin
    strobe    = '0;
    stateNext = stateQ;
    case (stateQ)
      ST_IDLE: begin
        if (reqValid) begin
          if (!numLegal) begin
            strobe.pulseErr = 1'b1;
          end else begin
            case (irqKind_e'(reqKind))
              KIND_LEGACY: begin
                strobe.setLeg    = 1'b1;
                strobe.pulseDone = 1'b1;
                stateNext        = ST_LEG;
              end
              KIND_MSI: begin
                strobe.setMsi = 1'b1;
                stateNext     = ST_MSI;
              end
              KIND_MSIX: begin
                strobe.setMsix = 1'b1;
                stateNext      = ST_MSIX;
              end
              default: strobe.pulseErr = 1'b1;
            endcase
          end
        end
      end
      ST_LEG: begin
        if (clrLegacy) begin
          strobe.clrLeg = 1'b1;
          stateNext     = ST_IDLE;
        end
      end
      ST_MSI: begin
        if (msiAck) begin
          strobe.clrMsi    = 1'b1;
          strobe.pulseDone = 1'b1;
          stateNext        = ST_IDLE;
        end
      end
      ST_MSIX: begin
        if (msixAck) begin
          strobe.clrMsix   = 1'b1;
          strobe.pulseDone = 1'b1;
          stateNext        = ST_IDLE;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
    if (stateQ != ST_IDLE && reqValid) strobe.pulseBusy = 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateNext;
  end

endmodule

// File: rtl/intr_dispatch.sv
module intr_dispatch
  import intr_pkg::*;
#(
  parameter int NUM_W    = 12,
  parameter int MSI_MAX  = 32,
  parameter int MSIX_MAX = 2048,
  localparam int MSI_VW  = $clog2(MSI_MAX),
  localparam int MSIX_VW = $clog2(MSIX_MAX)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               reqValid,
  input  logic [1:0]         reqKind,
  input  logic [NUM_W-1:0]   reqNum,
  output logic               reqDone,
  output logic               reqErr,
  output logic               reqBusy,
  input  logic               clrLegacy,
  output logic               legacyIrq,
  output logic               msiValid,
  output logic [MSI_VW-1:0]  msiVector,
  input  logic               msiAck,
  output logic               msixValid,
  output logic [MSIX_VW-1:0] msixVector,
  input  logic               msixAck
);

  ctrlStrobe_t strobe;
  logic        numLegal;

  intr_ctrl uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .reqValid  (reqValid),
    .reqKind   (reqKind),
    .numLegal  (numLegal),
    .clrLegacy (clrLegacy),
    .msiAck    (msiAck),
    .msixAck   (msixAck),
    .strobe    (strobe)
  );

  intr_datapath #(.NUM_W(NUM_W), .MSI_MAX(MSI_MAX), .MSIX_MAX(MSIX_MAX)) uData (
    .clk        (clk),
    .rstN       (rstN),
    .reqKind    (reqKind),
    .reqNum     (reqNum),
    .strobe     (strobe),
    .numLegal   (numLegal),
    .reqDone    (reqDone),
    .reqErr     (reqErr),
    .reqBusy    (reqBusy),
    .legacyIrq  (legacyIrq),
    .msiValid   (msiValid),
    .msiVector  (msiVector),
    .msixValid  (msixValid),
    .msixVector (msixVector)
  );

endmodule

// File: rtl/intr_dispatch_chk.sv
module intr_dispatch_chk #(
  parameter int NUM_W    = 12,
  parameter int MSI_MAX  = 32,
  parameter int MSIX_MAX = 2048,
  localparam int MSI_VW  = $clog2(MSI_MAX),
  localparam int MSIX_VW = $clog2(MSIX_MAX)
) (
  input logic               clk,
  input logic               rstN,
  input logic               reqValid,
  input logic [1:0]         reqKind,
  input logic [NUM_W-1:0]   reqNum,
  input logic               reqDone,
  input logic               reqErr,
  input logic               reqBusy,
  input logic               clrLegacy,
  input logic               legacyIrq,
  input logic               msiValid,
  input logic [MSI_VW-1:0]  msiVector,
  input logic               msiAck,
  input logic               msixValid,
  input logic [MSIX_VW-1:0] msixVector,
  input logic               msixAck
);

  AST_ONE_OUTPUT: assert property (@(posedge clk) disable iff (!rstN)
    $countones({legacyIrq, msiValid, msixValid}) <= 1); // R8

  AST_LEG_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    legacyIrq && !clrLegacy |=> legacyIrq); // R2

  AST_LEG_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    legacyIrq && clrLegacy |=> !legacyIrq); // R2

  AST_MSI_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    msiValid && !msiAck |=> msiValid && $stable(msiVector)); // R3

  AST_MSIX_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    msixValid && !msixAck |=> msixValid && $stable(msixVector)); // R4

  AST_MSI_ACK_DONE: assert property (@(posedge clk) disable iff (!rstN)
    msiValid && msiAck |=> !msiValid && reqDone); // R5

  AST_MSIX_ACK_DONE: assert property (@(posedge clk) disable iff (!rstN)
    msixValid && msixAck |=> !msixValid && reqDone); // R5

  AST_ERR_NO_OUTPUT: assert property (@(posedge clk) disable iff (!rstN)
    reqErr |-> $stable({legacyIrq, msiValid, msixValid}) && !reqDone); // R6

  AST_BUSY_OR_ERR: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({reqErr, reqBusy})); // R7

endmodule

bind intr_dispatch intr_dispatch_chk #(
  .NUM_W(NUM_W), .MSI_MAX(MSI_MAX), .MSIX_MAX(MSIX_MAX)
) uChk (.*);

// File: tb/sim_intr_dispatch.sv
`timescale 1ns/1ps
module sim_intr_dispatch;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [1:0]  reqKind = '0;
  logic [11:0] reqNum = '0;
  logic        clrLegacy = 1'b0;
  logic        msiAck = 1'b0;
  logic        msixAck = 1'b0;
  logic        reqDone, reqErr, reqBusy, legacyIrq, msiValid, msixValid;
  logic [4:0]  msiVector;
  logic [10:0] msixVector;

  int checks = 0;
  int failures = 0;

  typedef struct {
    logic  done, err, busy, leg, msi, msix;
    int    msiVec, msixVec;
    string tag;
  } exp_t;

  exp_t expQ[$];

  always #10 clk = ~clk; // 50 MHz

  intr_dispatch u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqKind(reqKind), .reqNum(reqNum),
    .reqDone(reqDone), .reqErr(reqErr), .reqBusy(reqBusy), .clrLegacy(clrLegacy),
    .legacyIrq(legacyIrq), .msiValid(msiValid), .msiVector(msiVector), .msiAck(msiAck),
    .msixValid(msixValid), .msixVector(msixVector), .msixAck(msixAck)
  );

  task automatic check(input logic ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  function automatic exp_t mk(input logic d, e, b, l, m, x, input int mv, xv, input string tag);
    exp_t r;
    r.done = d; r.err = e; r.busy = b; r.leg = l; r.msi = m; r.msix = x;
    r.msiVec = mv; r.msixVec = xv; r.tag = tag;
    return r;
  endfunction

  // monitor: compare each result cycle against the oldest expected item
  logic prevMsi = 1'b0, prevMsix = 1'b0;
  always @(negedge clk) begin
    if (rstN) begin
      if (reqDone || reqErr || reqBusy || (msiValid && !prevMsi) || (msixValid && !prevMsix)) begin
        if (expQ.size() == 0) begin
          checks++; failures++;
          $display("FAIL unexpected result actual=%b expected=none",
                   {reqDone, reqErr, reqBusy, legacyIrq, msiValid, msixValid});
        end else begin
          exp_t e;
          logic [5:0] got, want;
          logic ok;
          e = expQ.pop_front();
          got  = {reqDone, reqErr, reqBusy, legacyIrq, msiValid, msixValid};
          want = {e.done, e.err, e.busy, e.leg, e.msi, e.msix};
          ok = (got == want);
          if (e.msi && ok)  ok = (int'(msiVector) == e.msiVec);
          if (e.msix && ok) ok = (int'(msixVector) == e.msixVec);
          check(ok, e.tag, int'({got, 11'(msiValid ? msiVector : msixVector)}),
                int'({want, 11'(e.msi ? e.msiVec : e.msixVec)}));
        end
      end
      prevMsi  <= msiValid;
      prevMsix <= msixValid;
    end
  end

  task automatic sendReq(input logic [1:0] k, input int n, input exp_t e);
    @(posedge clk); #2;
    expQ.push_back(e);
    reqValid = 1'b1; reqKind = k; reqNum = 12'(n);
    @(posedge clk); #2;
    reqValid = 1'b0;
  endtask

  task automatic pulseMsiAck(input logic pushDone, input exp_t e);
    @(posedge clk); #2;
    if (pushDone) expQ.push_back(e);
    msiAck = 1'b1;
    @(posedge clk); #2;
    msiAck = 1'b0;
  endtask

  task automatic pulseMsixAck(input logic pushDone, input exp_t e);
    @(posedge clk); #2;
    if (pushDone) expQ.push_back(e);
    msixAck = 1'b1;
    @(posedge clk); #2;
    msixAck = 1'b0;
  endtask

  task automatic pulseClr();
    @(posedge clk); #2;
    clrLegacy = 1'b1;
    @(posedge clk); #2;
    clrLegacy = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic expectQuiet(input string tag);
    @(negedge clk);
    check({legacyIrq, msiValid, msixValid} == 3'b000, tag,
          int'({legacyIrq, msiValid, msixValid}), 0);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : stim
    exp_t none;
    none = mk(0, 0, 0, 0, 0, 0, 0, 0, "");
    repeat (3) @(posedge clk);
    #2 rstN = 1'b1;
    @(negedge clk);
    check({reqDone, reqErr, reqBusy, legacyIrq, msiValid, msixValid} == 6'b0,
          "R8 reset state", int'({reqDone, reqErr, reqBusy, legacyIrq, msiValid, msixValid}), 0);

    // R1 legacy raise
    sendReq(2'd0, 0, mk(1, 0, 0, 1, 0, 0, 0, 0, "R1 legacy raise"));
    idle(4);
    @(negedge clk);
    check(legacyIrq == 1'b1, "R2 legacy held", int'(legacyIrq), 1);
    // R7 refused while legacy outstanding
    sendReq(2'd1, 5, mk(0, 0, 1, 1, 0, 0, 0, 0, "R7 busy during legacy"));
    idle(2);
    // R9 stray acks
    pulseMsiAck(1'b0, none);
    pulseMsixAck(1'b0, none);
    idle(1);
    @(negedge clk);
    check(legacyIrq && !msiValid && !msixValid && !reqDone, "R9 stray acks ignored",
          int'({legacyIrq, msiValid, msixValid, reqDone}), 4'b1000);
    // R2 clear
    pulseClr();
    @(negedge clk);
    check(legacyIrq == 1'b0, "R2 legacy cleared", int'(legacyIrq), 0);

    // R3 MSI low and high ends
    sendReq(2'd1, 1, mk(0, 0, 0, 0, 1, 0, 0, 0, "R3 msi num 1"));
    idle(3);
    @(negedge clk);
    check(msiValid && msiVector == 5'd0, "R3 msi held", int'(msiVector), 0);
    pulseMsiAck(1'b1, mk(1, 0, 0, 0, 0, 0, 0, 0, "R5 msi ack done"));
    sendReq(2'd1, 32, mk(0, 0, 0, 0, 1, 0, 31, 0, "R3 msi num 32"));
    sendReq(2'd2, 7, mk(0, 0, 1, 0, 1, 0, 31, 0, "R7 busy during msi"));
    idle(1);
    @(negedge clk);
    check(msiValid && msiVector == 5'd31, "R7 msi vector kept", int'(msiVector), 31);
    pulseMsiAck(1'b1, mk(1, 0, 0, 0, 0, 0, 0, 0, "R5 msi ack done 32"));

    // R4 MSI-X ends
    sendReq(2'd2, 2048, mk(0, 0, 0, 0, 0, 1, 0, 2047, "R4 msix num 2048"));
    idle(5);
    @(negedge clk);
    check(msixValid && msixVector == 11'd2047, "R4 msix held", int'(msixVector), 2047);
    pulseMsixAck(1'b1, mk(1, 0, 0, 0, 0, 0, 0, 0, "R5 msix ack done"));
    sendReq(2'd2, 1, mk(0, 0, 0, 0, 0, 1, 0, 0, "R4 msix num 1"));
    pulseMsixAck(1'b1, mk(1, 0, 0, 0, 0, 0, 0, 0, "R5 msix ack done 1"));
    sendReq(2'd2, 1000, mk(0, 0, 0, 0, 0, 1, 0, 999, "R4 msix num 1000"));
    pulseMsixAck(1'b1, mk(1, 0, 0, 0, 0, 0, 0, 0, "R5 msix ack done 1000"));

    // R6 illegal requests
    sendReq(2'd3, 0, mk(0, 1, 0, 0, 0, 0, 0, 0, "R6 kind 3"));
    expectQuiet("R6 kind 3 no output");
    sendReq(2'd0, 5, mk(0, 1, 0, 0, 0, 0, 0, 0, "R6 legacy num 5"));
    expectQuiet("R6 legacy nonzero no output");
    sendReq(2'd1, 0, mk(0, 1, 0, 0, 0, 0, 0, 0, "R6 msi num 0"));
    sendReq(2'd1, 33, mk(0, 1, 0, 0, 0, 0, 0, 0, "R6 msi num 33"));
    expectQuiet("R6 msi range no output");
    sendReq(2'd2, 0, mk(0, 1, 0, 0, 0, 0, 0, 0, "R6 msix num 0"));
    sendReq(2'd2, 2049, mk(0, 1, 0, 0, 0, 0, 0, 0, "R6 msix num 2049"));
    expectQuiet("R6 msix range no output");

    // R9 stray clear and acks while idle
    pulseClr();
    pulseMsiAck(1'b0, none);
    pulseMsixAck(1'b0, none);
    expectQuiet("R9 stray inputs while idle");
    @(negedge clk);
    check(!reqDone, "R9 no done from stray ack", int'(reqDone), 0);

    // legacy again after errors
    sendReq(2'd0, 0, mk(1, 0, 0, 1, 0, 0, 0, 0, "R1 legacy raise again"));
    pulseClr();
    idle(3);

    checks++;
    if (expQ.size() != 0) begin
      failures++;
      $display("FAIL R8 pending results actual=%0d expected=0", expQ.size());
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule